// File: doc/BRIEF.md
# Validated Receive Block Staging Buffer

This block sits on the subsystem side of a serial-bus remote terminal and collects the data words of one receive message. Each 16-bit word arrives over an 8-bit highway as two bytes. The high byte comes first. A byte-select line marks which half is on the highway, and a strobe clocks each byte in. The buffer answers each data request from the terminal by pulling its acknowledge low.

Words are written into a shadow bank and are not visible to the consumer. A low-going validation pulse after the last word hands the whole block over. The banks swap roles, and the committed word count takes the number of words in the block. The block can end with no validation pulse, for example because of a message error or because the terminal switched to another bus. In that case the next initialization pulse starts a fresh block, and the pending words never reach the read port.

All inputs are sampled on the block clock and are assumed to be synchronized upstream. The init, validation and strobe lines act on their sampled edges.

Top module: `rx_block_stager`

## Requirements
- R1: After reset, `ack_n` is high, `commit_count` is 0 and `overflow` is 0.
- R2: `ack_n` equals the value `req_n` had at the previous clock edge: it goes low one cycle after a request is sampled and returns high one cycle after the request is released.
- R3: A rising edge of `strobe` while `req_n` is low captures `byte_in`. With `hi_sel`=1 it holds the high byte. With `hi_sel`=0 it completes the word {high, low} and writes it at the next word index, starting from index 0.
- R4: Strobes sampled while `req_n` is high capture nothing.
- R5: A falling edge of `valid_n` commits the pending block. `commit_count` becomes its word count, and `rd_data` at `rd_addr`=i returns word i.
- R6: Without a validation edge, `commit_count` and the committed contents stay unchanged. A falling edge of `init_n` discards the pending words, and the next block starts at index 0.
- R7: A completed word beyond DEPTH (32) words is dropped and sets `overflow`, which stays set until reset.
- R8: A low byte with no high byte held since the last word, init or commit is ignored. When two high bytes arrive in a row, the later one is used.
- R9: Words written after a commit do not change the committed view until their own validation edge.
- R10: A strobe sampled in the same cycle as an `init_n` or `valid_n` falling edge is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_n | input | 1 | Active-low start-of-block pulse |
| req_n | input | 1 | Active-low data request from the terminal |
| strobe | input | 1 | Byte strobe; rising edge captures a byte |
| hi_sel | input | 1 | 1 = high byte, 0 = low byte |
| byte_in | input | 8 | Highway byte |
| valid_n | input | 1 | Active-low good-block pulse |
| ack_n | output | 1 | Active-low acknowledge |
| commit_count | output | 6 | Words in the committed block |
| overflow | output | 1 | Sticky overflow flag |
| rd_addr | input | 5 | Read index into the committed block |
| rd_data | output | 16 | Committed word at `rd_addr` |

## Verification
The hardest case to reach is the boundary between an abandoned block and the committed one. Shadow words must be written, then dropped by a fresh init, while the read port still shows the earlier block unchanged. To reach it, the stimulus commits a block of known content, streams a second block, and restarts it with init before any validation edge. It then reads back every committed index and checks the count. A sweep over every block length from 0 to 32 also runs, with arithmetic patterns per length. It is followed by bursts that run past the depth, orphan low bytes, and strobes that coincide with init.

// File: rtl/rx_block_stager.sv
module rx_block_stager #(
  parameter int DEPTH = 32,
  parameter int BW    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          init_n,
  input  logic                          req_n,
  input  logic                          strobe,
  input  logic                          hi_sel,
  input  logic [BW-1:0]                 byte_in,
  input  logic                          valid_n,
  output logic                          ack_n,
  output logic [$clog2(DEPTH+1)-1:0]    commit_count,
  output logic                          overflow,
  input  logic [$clog2(DEPTH)-1:0]      rd_addr,
  output logic [2*BW-1:0]               rd_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam int DW = 2*BW;

  logic [DW-1:0] mem [2][DEPTH];
  logic          rd_bank;
  logic [CW-1:0] wptr;
  logic [BW-1:0] hi_byte;
  logic          hi_held;
  logic          strb_q, init_q, valid_q;

  wire strb_rise  = strobe & ~strb_q & ~req_n;
  wire init_fall  = ~init_n & init_q;
  wire valid_fall = ~valid_n & valid_q;
  wire boundary   = init_fall | valid_fall;
  wire take_lo    = strb_rise & ~hi_sel & hi_held & ~boundary;
  wire room       = wptr < CW'(DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q  <= 1'b0;
      init_q  <= 1'b1;
      valid_q <= 1'b1;
      ack_n   <= 1'b1;
    end else begin
      strb_q  <= strobe;
      init_q  <= init_n;
      valid_q <= valid_n;
      ack_n   <= req_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bank      <= 1'b0;
      wptr         <= '0;
      hi_byte      <= '0;
      hi_held      <= 1'b0;
      commit_count <= '0;
      overflow     <= 1'b0;
    end else if (boundary) begin
      wptr    <= '0;
      hi_held <= 1'b0;
      if (valid_fall) begin
        rd_bank      <= ~rd_bank;
        commit_count <= wptr;
      end
    end else if (strb_rise) begin
      if (hi_sel) begin
        hi_byte <= byte_in;
        hi_held <= 1'b1;
      end else if (hi_held) begin
        hi_held <= 1'b0;
        if (room) wptr <= wptr + 1'b1;
        else      overflow <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take_lo && room) mem[~rd_bank][wptr[AW-1:0]] <= {hi_byte, byte_in};
  end

  assign rd_data = mem[rd_bank][rd_addr];

  a_r1_reset_idle: assert property (@(posedge clk) $rose(rst_n) |-> (ack_n && commit_count == 0 && !overflow));
  a_r2_ack_follows: assert property (@(posedge clk) disable iff (!rst_n) $fell(req_n) |=> !ack_n);
  a_r2_ack_release: assert property (@(posedge clk) disable iff (!rst_n) $rose(req_n) |=> ack_n);
  a_r4_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n) (req_n && init_n && valid_n) |=> $stable(wptr));
  a_r6_count_held: assert property (@(posedge clk) disable iff (!rst_n) valid_n |=> $stable(commit_count));
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n) overflow |=> overflow);
  a_r7_bound: assert property (@(posedge clk) disable iff (!rst_n) (wptr <= CW'(DEPTH)) && (commit_count <= CW'(DEPTH)));
endmodule

// File: tb/rx_block_stager_test.sv
module rx_block_stager_test;
  localparam int CLK_P = 10;
  localparam int DEPTH = 32;

  logic clk = 0, rst_n = 0, init_n = 1, req_n = 1, strobe = 0, hi_sel = 0, valid_n = 1;
  logic [7:0] byte_in = 0;
  logic [4:0] rd_addr = 0;
  logic ack_n, overflow;
  logic [5:0] commit_count;
  logic [15:0] rd_data;
  int errors = 0, checks = 0;
  bit done = 0;

  rx_block_stager uut (.clk(clk), .rst_n(rst_n), .init_n(init_n), .req_n(req_n), .strobe(strobe),
    .hi_sel(hi_sel), .byte_in(byte_in), .valid_n(valid_n), .ack_n(ack_n),
    .commit_count(commit_count), .overflow(overflow), .rd_addr(rd_addr), .rd_data(rd_data));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic put_byte(input logic hs, input logic [7:0] b);
    tick(); hi_sel = hs; byte_in = b; strobe = 1;
    tick(); strobe = 0;
  endtask

  task automatic put_word(input logic [15:0] w);
    put_byte(1, w[15:8]);
    put_byte(0, w[7:0]);
  endtask

  task automatic pulse_init(); tick(); init_n = 0; tick(); init_n = 1; endtask
  task automatic pulse_valid(); tick(); valid_n = 0; tick(); valid_n = 1; endtask

  function automatic logic [15:0] pat(input int blk, input int i);
    return 16'((blk * 16'h9E37) ^ (i * 16'h0B31) ^ 16'h5A00);
  endfunction

  task automatic read_block(input string req, input int blk, input int n);
    for (int i = 0; i < n; i++) begin
      rd_addr = 5'(i); #1;
      chk(req, rd_data, pat(blk, i));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    tick(); tick(); rst_n = 1; tick();
    chk("R1 ack", ack_n, 1);
    chk("R1 count", commit_count, 0);
    chk("R1 ovf", overflow, 0);

    req_n = 0; tick();
    chk("R2 ack low", ack_n, 0);
    req_n = 1; tick();
    chk("R2 ack high", ack_n, 1);

    req_n = 0;
    for (int n = 0; n <= DEPTH; n++) begin
      pulse_init();
      for (int i = 0; i < n; i++) put_word(pat(n, i));
      pulse_valid(); tick();
      chk("R5 count", commit_count, n);
      read_block("R3 R5 data", n, n);
    end

    pulse_init();
    for (int i = 0; i < 5; i++) put_word(pat(77, i));
    tick();
    chk("R6 count held", commit_count, DEPTH);
    read_block("R9 R6 view held", DEPTH, DEPTH);
    pulse_init();
    for (int i = 0; i < 3; i++) put_word(pat(78, i));
    pulse_valid(); tick();
    chk("R6 restart count", commit_count, 3);
    read_block("R6 restart data", 78, 3);

    pulse_init();
    req_n = 1;
    put_word(16'hDEAD);
    req_n = 0;
    pulse_valid(); tick();
    chk("R4 ignored", commit_count, 0);

    pulse_init();
    put_byte(0, 8'h11);
    put_byte(1, 8'h22);
    put_byte(1, pat(90, 0)[15:8]);
    put_byte(0, pat(90, 0)[7:0]);
    put_byte(0, 8'h33);
    pulse_valid(); tick();
    chk("R8 orphan count", commit_count, 1);
    read_block("R8 data", 90, 1);

    tick(); init_n = 0; hi_sel = 1; byte_in = 8'hAB; strobe = 1;
    tick(); init_n = 1; strobe = 0;
    put_byte(0, 8'hCD);
    pulse_valid(); tick();
    chk("R10 dropped", commit_count, 0);

    chk("R7 clear before", overflow, 0);
    pulse_init();
    for (int i = 0; i < DEPTH + 2; i++) put_word(pat(91, i));
    pulse_valid(); tick();
    chk("R7 count", commit_count, DEPTH);
    chk("R7 ovf", overflow, 1);
    read_block("R7 data", 91, DEPTH);
    pulse_init(); put_word(pat(92, 0)); pulse_valid(); tick();
    chk("R7 sticky", overflow, 1);
    chk("R5 after ovf", commit_count, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule